// File: doc/BRIEF.md
# Two-Wire Bus Role and Direction Controller

This block keeps the role (master or slave) and the data direction (transmitter or receiver) of a two-wire serial bus interface. Software sets the role, direction and address format through two write ports. A bus front end reports start, stop, arbitration loss, the first received byte and the acknowledge that follows an address byte the block sent. From these events the block updates the role and direction flags.

After the address phase the direction flag is switched by hardware. A slave that matches its own address takes the received direction bit. A master that gets an acknowledge takes the inverse of the direction bit it sent. The flag is left alone in free data format, where no address is recognised, and also when the master gets no acknowledge. Software starts a transfer with one control write that sets all four control bits while the bus is idle. The block answers with a one-cycle start request to the front end.

Top module: `i2c_role_ctrl`

## Requirements
- R1: While reset is low at a clock edge, the master flag, transmitter flag, free-format flag and start request all become 0, so the block leaves reset as a slave receiver in addressing format.
- R2: A write to the address register (byte, bit 0 = format select, bits 7..1 = own 7-bit address) loads both fields; free_fmt equals bit 0 from the next cycle on.
- R3: A control write (ctl_wdata bit 7 = master, bit 6 = transmitter) loads both flags, visible the cycle after the write.
- R4: A stop or an arbitration loss clears the master and transmitter flags on the next edge, even if a control write arrives in the same cycle.
- R5: In slave role and addressing format, when the first byte after a start has bits 7..1 equal to the own address, the transmitter flag takes that byte's bit 0.
- R6: In slave role, a non-matching first byte, or any later byte before the next start, leaves the transmitter flag unchanged.
- R7: In master role and addressing format, an acknowledged address byte sets the transmitter flag to the inverse of the sent direction bit.
- R8: In master role, an address byte with no acknowledge leaves the transmitter flag unchanged.
- R9: In free data format, address bytes and acknowledges never change the transmitter flag.
- R10: A control write with bits 7, 6, 5 and 4 all 1, made while bus_busy is 0 and ack_en is 1, raises start_req for exactly one cycle, the cycle after the write. A write that sets only some of these bits gives no pulse.
- R11: A start write made while bus_busy is 1, or while ack_en is 0, gives no start_req pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_wr | input | 1 | Address register write strobe |
| addr_wdata | input | 8 | Own address (7..1) and format select (0) |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 4 | Bits 7..4: master, transmitter, bus-busy, pin |
| ack_en | input | 1 | Acknowledge enable setting |
| bus_busy | input | 1 | Bus-busy status from front end |
| ev_start | input | 1 | Start condition detected |
| ev_stop | input | 1 | Stop condition detected |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_rx_byte | input | 1 | A byte was received |
| rx_byte | input | 8 | Received byte |
| ev_addr_ack | input | 1 | Acknowledge slot after master's address byte |
| addr_ack_ok | input | 1 | 1 if the slave acknowledged |
| tx_dir | input | 1 | Direction bit the master sent |
| mst | output | 1 | Master flag |
| trx | output | 1 | Transmitter flag |
| start_req | output | 1 | One-cycle start generation request |
| free_fmt | output | 1 | Free data format selected |

## Verification
The hardest case to reach is the slave-side address compare, which is armed only for the first byte after a start. To show that later bytes are ignored, the stimulus first sends a non-matching address after a start. It then sends a byte that would match, with no new start in between, and checks that the transmitter flag does not move. The same matching byte is later sent after a fresh start, to show that it does switch the flag. Collisions between a stop or arbitration loss and a control write are driven in the same cycle to check their priority.

// File: rtl/i2c_role_pkg.sv
// Shared constants and types for the role/direction controller.
// Assumes a control write field laid out as bits 7..4 of the control byte.
package i2c_role_pkg;
    localparam int unsigned CTL_HI  = 7;
    localparam int unsigned CTL_LO  = 4;
    localparam int unsigned MST_BIT = 7;
    localparam int unsigned TRX_BIT = 6;
    localparam int unsigned BB_BIT  = 5;
    localparam int unsigned PIN_BIT = 4;

    typedef struct packed {
        logic mst;
        logic trx;
    } role_t;
endpackage

// File: rtl/i2c_addr_unit.sv
// Holds the own address and format select; compares the first byte after a
// start against the own address. Assumes ev_rx_byte is a one-cycle strobe.
module i2c_addr_unit #(
    parameter int unsigned ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W:0]   wdata,
    input  logic              ev_start,
    input  logic              ev_rx_byte,
    input  logic [ADDR_W:0]   rx_byte,
    output logic              free_fmt,
    output logic              hit,
    output logic              hit_dir
);
    logic [ADDR_W-1:0] own_q;
    logic              free_q;
    logic              armed_q;

    // Address register: own address and format select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q  <= '0;
            free_q <= 1'b0;
        end else if (wr) begin
            own_q  <= wdata[ADDR_W:1];
            free_q <= wdata[0];
        end
    end

    // Compare window: open from a start until the first byte arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)          armed_q <= 1'b0;
        else if (ev_start)   armed_q <= 1'b1;
        else if (ev_rx_byte) armed_q <= 1'b0;
    end

    // Match decode for the armed byte in addressing format.
    always_comb begin
        hit     = ev_rx_byte && armed_q && !free_q && (rx_byte[ADDR_W:1] == own_q);
        hit_dir = rx_byte[0];
    end

    assign free_fmt = free_q;

    // R6: the compare window closes after one byte.
    assert_window_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_byte && !ev_start) |=> !armed_q);
endmodule

// File: rtl/i2c_start_gen.sv
// Issues a one-cycle start request when software writes the full start
// pattern to an idle bus with acknowledge enabled. Assumes ctl_wr is a strobe.
module i2c_start_gen
    import i2c_role_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_wr,
    input  logic [CTL_HI:CTL_LO] ctl_wdata,
    input  logic                 bus_busy,
    input  logic                 ack_en,
    input  logic                 kill,
    output logic                 start_req
);
    logic pattern;

    // Full start pattern: all four control bits set.
    always_comb pattern = &ctl_wdata;

    // Start request register, one cycle per qualifying write.
    always_ff @(posedge clk) begin
        if (!rst_n) start_req <= 1'b0;
        else        start_req <= ctl_wr && pattern && !bus_busy && ack_en && !kill;
    end

    // R11: a busy bus suppresses the request.
    assert_no_start_when_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && bus_busy) |=> !start_req);
    // R10: the request never lasts longer than the write that made it.
    assert_start_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> !start_req);
endmodule

// File: rtl/i2c_role_regs.sv
// Master and transmitter flags. Priority: bus stop/arbitration loss, then
// software write, then hardware direction switching after the address phase.
module i2c_role_regs
    import i2c_role_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sw_wr,
    input  logic  sw_mst,
    input  logic  sw_trx,
    input  logic  kill,
    input  logic  free_fmt,
    input  logic  slave_hit,
    input  logic  slave_dir,
    input  logic  m_ack_ev,
    input  logic  m_ack_ok,
    input  logic  m_dir,
    output role_t role
);
    role_t q;

    // Role and direction update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (kill) begin
            q <= '0;
        end else if (sw_wr) begin
            q.mst <= sw_mst;
            q.trx <= sw_trx;
        end else if (!free_fmt) begin
            if (!q.mst && slave_hit)
                q.trx <= slave_dir;
            else if (q.mst && m_ack_ev && m_ack_ok)
                q.trx <= ~m_dir;
        end
    end

    assign role = q;

    // R4: stop or arbitration loss leaves a slave receiver.
    assert_kill_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (!q.mst && !q.trx));
    // R8: no acknowledge holds the direction.
    assert_nack_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mst && m_ack_ev && !m_ack_ok && !sw_wr && !kill) |=> $stable(q.trx));
    // R9: free format freezes hardware switching.
    assert_free_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (free_fmt && !sw_wr && !kill) |=> $stable(q.trx));
    // R6: a slave without a match keeps its direction.
    assert_nomatch_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.mst && !slave_hit && !sw_wr && !kill) |=> $stable(q.trx));
endmodule

// File: rtl/i2c_role_ctrl.sv
// Top: role and direction controller for a two-wire bus interface.
// Assumes all ev_* inputs are one-cycle strobes from a bus front end.
module i2c_role_ctrl
    import i2c_role_pkg::*;
#(
    parameter int unsigned ADDR_W = 7,
    localparam int unsigned AREG_W = ADDR_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 addr_wr,
    input  logic [AREG_W-1:0]    addr_wdata,
    input  logic                 ctl_wr,
    input  logic [CTL_HI:CTL_LO] ctl_wdata,
    input  logic                 ack_en,
    input  logic                 bus_busy,
    input  logic                 ev_start,
    input  logic                 ev_stop,
    input  logic                 ev_arb_lost,
    input  logic                 ev_rx_byte,
    input  logic [AREG_W-1:0]    rx_byte,
    input  logic                 ev_addr_ack,
    input  logic                 addr_ack_ok,
    input  logic                 tx_dir,
    output logic                 mst,
    output logic                 trx,
    output logic                 start_req,
    output logic                 free_fmt
);
    logic  kill;
    logic  hit;
    logic  hit_dir;
    role_t role;

    // Bus events that drop the block back to slave receiver.
    always_comb kill = ev_stop || ev_arb_lost;

    i2c_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .wr(addr_wr), .wdata(addr_wdata),
        .ev_start(ev_start), .ev_rx_byte(ev_rx_byte), .rx_byte(rx_byte),
        .free_fmt(free_fmt), .hit(hit), .hit_dir(hit_dir)
    );

    i2c_start_gen u_start (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .bus_busy(bus_busy), .ack_en(ack_en), .kill(kill), .start_req(start_req)
    );

    i2c_role_regs u_role (
        .clk(clk), .rst_n(rst_n), .sw_wr(ctl_wr),
        .sw_mst(ctl_wdata[MST_BIT]), .sw_trx(ctl_wdata[TRX_BIT]),
        .kill(kill), .free_fmt(free_fmt), .slave_hit(hit), .slave_dir(hit_dir),
        .m_ack_ev(ev_addr_ack), .m_ack_ok(addr_ack_ok), .m_dir(tx_dir), .role(role)
    );

    assign mst = role.mst;
    assign trx = role.trx;

    // R10: a start request always comes with master transmitter set.
    assert_start_as_master_tx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |-> (mst && trx));
endmodule

// File: tb/i2c_role_ctrl_test.sv
// Directed bench: one task per scenario, each checks its own results.
module i2c_role_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_wr = 0, ctl_wr = 0, ack_en = 1, bus_busy = 0;
    logic [7:0] addr_wdata = 0, rx_byte = 0;
    logic [7:4] ctl_wdata = 0;
    logic       ev_start = 0, ev_stop = 0, ev_arb_lost = 0, ev_rx_byte = 0;
    logic       ev_addr_ack = 0, addr_ack_ok = 0, tx_dir = 0;
    logic       mst, trx, start_req, free_fmt;
    int         n_chk = 0, n_fail = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    i2c_role_ctrl uut (
        .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .addr_wdata(addr_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ack_en(ack_en), .bus_busy(bus_busy),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_arb_lost(ev_arb_lost),
        .ev_rx_byte(ev_rx_byte), .rx_byte(rx_byte), .ev_addr_ack(ev_addr_ack),
        .addr_ack_ok(addr_ack_ok), .tx_dir(tx_dir),
        .mst(mst), .trx(trx), .start_req(start_req), .free_fmt(free_fmt)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wr_addr(input logic [7:0] d);
        @(negedge clk); addr_wr = 1; addr_wdata = d;
        @(negedge clk); addr_wr = 0;
    endtask

    task automatic wr_ctl(input logic [7:4] d);
        @(negedge clk); ctl_wr = 1; ctl_wdata = d;
        @(negedge clk); ctl_wr = 0;
    endtask

    task automatic bus_start;
        @(negedge clk); ev_start = 1;
        @(negedge clk); ev_start = 0;
    endtask

    task automatic rx(input logic [7:0] b);
        @(negedge clk); ev_rx_byte = 1; rx_byte = b;
        @(negedge clk); ev_rx_byte = 0;
    endtask

    task automatic m_ack(input logic ok, input logic dir);
        @(negedge clk); ev_addr_ack = 1; addr_ack_ok = ok; tx_dir = dir;
        @(negedge clk); ev_addr_ack = 0;
    endtask

    task automatic t_reset;
        chk("R1 mst", mst, 0); chk("R1 trx", trx, 0);
        chk("R1 start_req", start_req, 0); chk("R1 free_fmt", free_fmt, 0);
    endtask

    task automatic t_cfg;
        wr_addr(8'hA4);             // own 0x52, addressing format
        chk("R2 free_fmt=0", free_fmt, 0);
        wr_ctl(4'h8);
        chk("R3 mst", mst, 1); chk("R3 trx", trx, 0); chk("R10 partial no pulse", start_req, 0);
        wr_ctl(4'h4);
        chk("R3 mst", mst, 0); chk("R3 trx", trx, 1);
    endtask

    task automatic t_kill;
        wr_ctl(4'hC);
        @(negedge clk); ev_stop = 1;
        @(negedge clk); ev_stop = 0;
        chk("R4 stop mst", mst, 0); chk("R4 stop trx", trx, 0);
        @(negedge clk); ev_arb_lost = 1; ctl_wr = 1; ctl_wdata = 4'hC;
        @(negedge clk); ev_arb_lost = 0; ctl_wr = 0;
        chk("R4 lost+write mst", mst, 0); chk("R4 lost+write trx", trx, 0);
    endtask

    task automatic t_slave;
        wr_ctl(4'h0);
        bus_start; rx(8'hA5);
        chk("R5 match dir1", trx, 1);
        bus_start; rx(8'hA4);
        chk("R5 match dir0", trx, 0);
        bus_start; rx(8'hB1);
        chk("R6 mismatch", trx, 0);
        rx(8'hA5);
        chk("R6 second byte", trx, 0);
    endtask

    task automatic t_master;
        wr_ctl(4'h8);
        m_ack(1, 0);
        chk("R7 dir0 -> tx", trx, 1);
        wr_ctl(4'hC);
        m_ack(1, 1);
        chk("R7 dir1 -> rx", trx, 0);
        wr_ctl(4'hC);
        m_ack(0, 1);
        chk("R8 nack hold", trx, 1);
        chk("R8 still master", mst, 1);
    endtask

    task automatic t_free;
        wr_addr(8'hA5);
        chk("R2 free_fmt=1", free_fmt, 1);
        wr_ctl(4'h0);
        bus_start; rx(8'hA5);
        chk("R9 slave hold", trx, 0);
        wr_ctl(4'h8);
        m_ack(1, 0);
        chk("R9 master hold", trx, 0);
        wr_addr(8'hA4);
    endtask

    task automatic t_start;
        bus_busy = 0; ack_en = 1;
        wr_ctl(4'hF);
        chk("R10 pulse", start_req, 1);
        @(negedge clk);
        chk("R10 one cycle", start_req, 0);
        wr_ctl(4'hE);
        chk("R10 partial", start_req, 0);
        bus_busy = 1;
        wr_ctl(4'hF);
        chk("R11 busy", start_req, 0);
        bus_busy = 0; ack_en = 0;
        wr_ctl(4'hF);
        chk("R11 ack_en=0", start_req, 0);
        ack_en = 1;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1;
        t_cfg; t_kill; t_slave; t_master; t_free; t_start;
        done = 1;
        summary;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            summary;
        end
    end
endmodule